// File: doc/BRIEF.md
# Operand-Field Alteration Prefix Unit

This unit sits beside the decode stage and carries out three prefix operations. Each prefix redirects one register-address field of the next instruction: the result (write-back) field, the destination field or the source field. When a prefix executes, the execute stage gives the unit the prefix kind, the value of the prefix's D register (the offset) and its S operand, which is a register value or an immediate (the base). The unit adds offset and base, keeps the low nine bits of the sum as a register address and stores that address in a register. On the following cycle it puts the stored address in place of the chosen field of the next decoded instruction.

The sum is registered so that the prefixed instruction still decodes in a single cycle, with no path that spans two clocks. A prefix only adds. It does not accumulate into D, it writes no pointer back and it never changes the carry or zero flags. An override lasts until the next non-prefix instruction issues, or until a branch or flush cancels it. Prefixes of different kinds can be chained so that one instruction has several fields redirected.

Top module: `opalt_unit`

## Requirements
- R1: After reset no override is pending, so out_r, out_d and out_s equal dec_r, dec_d and dec_s.
- R2: A prefix with pfx_kind 0 makes out_r equal (pfx_d + pfx_s) mod 512 from the next cycle on. out_d and out_s are not touched.
- R3: A prefix with pfx_kind 1 makes out_d equal (pfx_d + pfx_s) mod 512 from the next cycle on. out_r and out_s are not touched.
- R4: A prefix with pfx_kind 2 makes out_s equal (pfx_d + pfx_s) mod 512 from the next cycle on. out_r and out_d are not touched.
- R5: A cycle with dec_valid and dec_issue high clears every pending override at its clock edge. If a prefix is also presented in that same cycle, only that new prefix stays pending.
- R6: flush high clears every pending override at its clock edge, including a prefix presented in the same cycle.
- R7: Two prefixes of different kinds presented in successive cycles both apply to the next instruction. If the same kind is presented twice, the later sum replaces the earlier one.
- R8: The flag-write bits pfx_wcz have no effect on any address. The same address comes out whatever value those bits carry.
- R9: pfx_kind 3 is reserved. A prefix with that code leaves every field and every pending override unchanged.
- R10: Bits of pfx_d and pfx_s above bit 8 do not affect the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_valid | input | 1 | A prefix executes this cycle |
| pfx_kind | input | 2 | 0 result, 1 destination, 2 source, 3 reserved |
| pfx_wcz | input | 2 | Flag-write bits of the prefix encoding (ignored) |
| pfx_d | input | 32 | Offset operand (D register value) |
| pfx_s | input | 32 | Base operand (S register or immediate) |
| flush | input | 1 | Branch or flush cancels the pending overrides |
| dec_valid | input | 1 | The decode stage holds a non-prefix instruction |
| dec_issue | input | 1 | That instruction issues this cycle |
| dec_r | input | 9 | Raw result field |
| dec_d | input | 9 | Raw destination field |
| dec_s | input | 9 | Raw source field |
| out_r | output | 9 | Result field after alteration |
| out_d | output | 9 | Destination field after alteration |
| out_s | output | 9 | Source field after alteration |

## Verification
Each sum is registered at the clock edge that ends the prefix cycle and is visible combinationally on the altered field through the whole next cycle. A clear caused by an issue or a flush takes effect at the edge that ends the cycle in which it was asserted. The bench drives its inputs at the falling edge, then samples the outputs shortly afterwards in that same low phase. The check for a prefix therefore falls in the cycle right after the prefix, and the check for a clear falls in the cycle right after the issue or flush. The expected addresses are worked out in the bench as the 9-bit sum of offset and base, over a sweep of offsets, bases and all three field kinds.

// File: rtl/opalt_pkg.sv
// Shared widths and the prefix-kind encoding for the operand-alteration unit.
package opalt_pkg;
    localparam int ADDR_W  = 9;   // register address width
    localparam int DATA_W  = 32;  // operand width
    localparam int NFIELD  = 3;   // result, destination, source

    typedef enum logic [1:0] {
        KIND_RES  = 2'd0,
        KIND_DST  = 2'd1,
        KIND_SRC  = 2'd2,
        KIND_NONE = 2'd3
    } pfx_kind_e;
endpackage

// File: rtl/opalt_adder.sv
// Forms a register address as offset + base, truncated to ADDR_W bits.
// Assumes the caller has already dropped the operand bits above ADDR_W.
module opalt_adder #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Plain modular add, no carry out kept.
    always_comb begin
        addr_o = offset_i + base_i;
    end
endmodule

// File: rtl/opalt_kind_dec.sv
// Turns a prefix kind into one load strobe per field.
// Assumes field index 0 = result, 1 = destination, 2 = source; the reserved code loads nothing.
module opalt_kind_dec
    import opalt_pkg::*;
#(
    parameter int NF = 3
) (
    input  logic          valid_i,
    input  logic          flush_i,
    input  logic [1:0]    kind_i,
    output logic [NF-1:0] load_o
);
    // One strobe per field; a flush in the same cycle suppresses every load.
    always_comb begin
        for (int f = 0; f < NF; f++) begin
            load_o[f] = valid_i && !flush_i && (kind_i == 2'(f)) && (kind_i != KIND_NONE);
        end
    end
endmodule

// File: rtl/opalt_slot.sv
// Holds one pending override: a valid flag and the registered address.
// Assumes a load takes priority over a clear, because a prefix that comes with an issue arms the next instruction.
module opalt_slot #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              vld_o,
    output logic [ADDR_W-1:0] addr_o
);
    // Valid flag: set by a load, dropped by a clear, reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n)       vld_o <= 1'b0;
        else if (load_i)  vld_o <= 1'b1;
        else if (clear_i) vld_o <= 1'b0;
    end

    // Address register: captures the sum on a load, otherwise holds its value.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (load_i) addr_o <= addr_i;
    end
endmodule

// File: rtl/opalt_field_mux.sv
// Puts a pending override address in place of a raw decoded field.
// Assumes vld_i comes straight from a register, so this mux is the only logic added to the decode path.
module opalt_field_mux #(
    parameter int ADDR_W = 9
) (
    input  logic              vld_i,
    input  logic [ADDR_W-1:0] ovr_i,
    input  logic [ADDR_W-1:0] raw_i,
    output logic [ADDR_W-1:0] fld_o
);
    // Select the override when one is pending.
    always_comb begin
        fld_o = vld_i ? ovr_i : raw_i;
    end
endmodule

// File: rtl/opalt_unit.sv
// Operand-field alteration prefix unit. It registers offset + base for a prefix and
// replaces the chosen field (result, destination or source) of the next decoded instruction.
// Assumes pfx_valid and a non-prefix issue describe different instructions. Flag bits of the
// prefix and operand bits above the address width are ignored.
module opalt_unit
    import opalt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_valid,
    input  logic [1:0]        pfx_kind,
    input  logic [1:0]        pfx_wcz,
    input  logic [DATA_W-1:0] pfx_d,
    input  logic [DATA_W-1:0] pfx_s,
    input  logic              flush,
    input  logic              dec_valid,
    input  logic              dec_issue,
    input  logic [ADDR_W-1:0] dec_r,
    input  logic [ADDR_W-1:0] dec_d,
    input  logic [ADDR_W-1:0] dec_s,
    output logic [ADDR_W-1:0] out_r,
    output logic [ADDR_W-1:0] out_d,
    output logic [ADDR_W-1:0] out_s
);
    localparam int HI_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] sum;
    logic [NFIELD-1:0] load;
    logic              clr;
    logic [NFIELD-1:0] vld;
    logic [ADDR_W-1:0] ovr [NFIELD];
    logic [ADDR_W-1:0] raw [NFIELD];
    logic [ADDR_W-1:0] fld [NFIELD];
    logic              unused_bits;

    // Flag bits and high operand bits have no effect on the address.
    assign unused_bits = ^{pfx_wcz, pfx_d[DATA_W-1 -: HI_W], pfx_s[DATA_W-1 -: HI_W]};

    // A flush or an issued instruction ends every pending override.
    assign clr = flush || (dec_valid && dec_issue);

    assign raw[0] = dec_r;
    assign raw[1] = dec_d;
    assign raw[2] = dec_s;

    opalt_adder #(.ADDR_W(ADDR_W)) u_add (
        .offset_i (pfx_d[ADDR_W-1:0]),
        .base_i   (pfx_s[ADDR_W-1:0]),
        .addr_o   (sum)
    );

    opalt_kind_dec #(.NF(NFIELD)) u_kdec (
        .valid_i (pfx_valid),
        .flush_i (flush),
        .kind_i  (pfx_kind),
        .load_o  (load)
    );

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        opalt_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load[f]),
            .clear_i (clr),
            .addr_i  (sum),
            .vld_o   (vld[f]),
            .addr_o  (ovr[f])
        );
        opalt_field_mux #(.ADDR_W(ADDR_W)) u_mux (
            .vld_i (vld[f]),
            .ovr_i (ovr[f]),
            .raw_i (raw[f]),
            .fld_o (fld[f])
        );
    end

    assign out_r = fld[0];
    assign out_d = fld[1];
    assign out_s = fld[2];
endmodule

// File: rtl/opalt_unit_chk.sv
// Checker for opalt_unit, attached through bind. It relates the prefix and clear inputs
// to the altered fields one cycle later.
module opalt_unit_chk
    import opalt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pfx_valid,
    input logic [1:0]        pfx_kind,
    input logic [DATA_W-1:0] pfx_d,
    input logic [DATA_W-1:0] pfx_s,
    input logic              flush,
    input logic              dec_valid,
    input logic              dec_issue,
    input logic [ADDR_W-1:0] dec_r,
    input logic [ADDR_W-1:0] dec_d,
    input logic [ADDR_W-1:0] dec_s,
    input logic [ADDR_W-1:0] out_r,
    input logic [ADDR_W-1:0] out_d,
    input logic [ADDR_W-1:0] out_s
);
    AST_RES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_valid && pfx_kind == 2'd0 && !flush) |=>
        out_r == ADDR_W'($past(pfx_d) + $past(pfx_s))); // R2

    AST_DST_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_valid && pfx_kind == 2'd1 && !flush) |=>
        out_d == ADDR_W'($past(pfx_d) + $past(pfx_s))); // R3

    AST_SRC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_valid && pfx_kind == 2'd2 && !flush) |=>
        out_s == ADDR_W'($past(pfx_d) + $past(pfx_s))); // R4

    AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_issue && !pfx_valid) |=>
        (out_r == dec_r && out_d == dec_d && out_s == dec_s)); // R5

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_r == dec_r && out_d == dec_d && out_s == dec_s)); // R6
endmodule

bind opalt_unit opalt_unit_chk u_chk (.*);

// File: tb/tb_opalt_unit.sv
// Self-checking bench for opalt_unit: reference model of the pending overrides, with sweeps over
// offsets, bases and field kinds.
module tb_opalt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_valid = 1'b0;
    logic [1:0]  pfx_kind = 2'd0;
    logic [1:0]  pfx_wcz = 2'd0;
    logic [31:0] pfx_d = '0;
    logic [31:0] pfx_s = '0;
    logic        flush = 1'b0;
    logic        dec_valid = 1'b0;
    logic        dec_issue = 1'b0;
    logic [8:0]  dec_r = '0;
    logic [8:0]  dec_d = '0;
    logic [8:0]  dec_s = '0;
    logic [8:0]  out_r;
    logic [8:0]  out_d;
    logic [8:0]  out_s;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model: one pending flag and address per field.
    bit       m_v [3];
    bit [8:0] m_a [3];

    always #5 clk = ~clk;

    opalt_unit dut (.*);

    task automatic cmp(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one prefix for one cycle and update the model. Called and returns at a falling edge.
    task automatic prefix(input logic [1:0] k, input logic [31:0] d, input logic [31:0] s,
                          input logic [1:0] wcz);
        pfx_valid = 1'b1; pfx_kind = k; pfx_d = d; pfx_s = s; pfx_wcz = wcz;
        @(negedge clk);
        pfx_valid = 1'b0; pfx_wcz = 2'd0;
        if (k != 2'd3) begin
            m_v[k] = 1'b1;
            m_a[k] = 9'((d + s) & 32'h1ff);
        end
    endtask

    // Present a decoded instruction, check all three fields against the model, optionally issue it.
    task automatic decode(input logic [8:0] r, input logic [8:0] d, input logic [8:0] s,
                          input bit issue, input string req);
        dec_valid = 1'b1; dec_issue = issue; dec_r = r; dec_d = d; dec_s = s;
        #1;
        cmp(req, out_r, m_v[0] ? m_a[0] : r);
        cmp(req, out_d, m_v[1] ? m_a[1] : d);
        cmp(req, out_s, m_v[2] ? m_a[2] : s);
        @(negedge clk);
        dec_valid = 1'b0; dec_issue = 1'b0;
        if (issue) begin
            m_v[0] = 1'b0; m_v[1] = 1'b0; m_v[2] = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] dv;
        logic [31:0] sv;
        for (int f = 0; f < 3; f++) begin m_v[f] = 1'b0; m_a[f] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state passes raw fields through
        decode(9'd11, 9'd22, 9'd33, 1'b0, "R1");

        // R2 R3 R4: sweep kinds, offsets and bases, including sums that wrap past 511
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 8; j++) begin
                    dv = 32'(i * 37);
                    sv = 32'(j * 71 + 200);
                    prefix(2'(k), dv, sv, 2'd0);
                    decode(9'(i + 5), 9'(j + 100), 9'(i * j), 1'b1,
                           k == 0 ? "R2" : (k == 1 ? "R3" : "R4"));
                end
            end
        end

        // R5: override gone after issue
        prefix(2'd1, 32'd7, 32'd9, 2'd0);
        decode(9'd1, 9'd2, 9'd3, 1'b1, "R5");
        decode(9'd4, 9'd5, 9'd6, 1'b0, "R5");
        // R5: override holds while the instruction stalls without issuing
        prefix(2'd2, 32'd300, 32'd300, 2'd0);
        decode(9'd1, 9'd2, 9'd3, 1'b0, "R5");
        decode(9'd1, 9'd2, 9'd3, 1'b1, "R5");
        // R5: a prefix presented together with an issue stays pending alone
        prefix(2'd0, 32'd10, 32'd20, 2'd0);
        pfx_valid = 1'b1; pfx_kind = 2'd1; pfx_d = 32'd40; pfx_s = 32'd2;
        dec_valid = 1'b1; dec_issue = 1'b1; dec_r = 9'd50; dec_d = 9'd51; dec_s = 9'd52;
        #1;
        cmp("R5", out_r, 9'd30);
        @(negedge clk);
        pfx_valid = 1'b0; dec_valid = 1'b0; dec_issue = 1'b0;
        m_v[0] = 1'b0; m_v[1] = 1'b1; m_a[1] = 9'd42; m_v[2] = 1'b0;
        decode(9'd60, 9'd61, 9'd62, 1'b1, "R5");

        // R6: flush cancels pending overrides
        prefix(2'd0, 32'd3, 32'd4, 2'd0);
        prefix(2'd2, 32'd5, 32'd6, 2'd0);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        m_v[0] = 1'b0; m_v[2] = 1'b0;
        decode(9'd70, 9'd71, 9'd72, 1'b0, "R6");
        // R6: a flush in the same cycle as a prefix wins
        pfx_valid = 1'b1; pfx_kind = 2'd1; pfx_d = 32'd1; pfx_s = 32'd1; flush = 1'b1;
        @(negedge clk);
        pfx_valid = 1'b0; flush = 1'b0;
        decode(9'd80, 9'd81, 9'd82, 1'b0, "R6");

        // R7: different kinds chained all apply
        prefix(2'd0, 32'd100, 32'd1, 2'd0);
        prefix(2'd1, 32'd100, 32'd2, 2'd0);
        prefix(2'd2, 32'd100, 32'd3, 2'd0);
        decode(9'd0, 9'd0, 9'd0, 1'b1, "R7");
        // R7: same kind twice, later wins (expected 300+250 mod 512 = 38)
        prefix(2'd1, 32'd5, 32'd5, 2'd0);
        prefix(2'd1, 32'd300, 32'd250, 2'd0);
        decode(9'd9, 9'd9, 9'd9, 1'b1, "R7");
        cmp("R7", m_a[1], 9'd38);

        // R8: flag bits change nothing
        for (int w = 0; w < 4; w++) begin
            prefix(2'd2, 32'd123, 32'd45, 2'(w));
            decode(9'd1, 9'd2, 9'd3, 1'b1, "R8");
        end

        // R9: reserved kind arms nothing and keeps existing overrides
        prefix(2'd3, 32'd77, 32'd88, 2'd0);
        decode(9'd13, 9'd14, 9'd15, 1'b0, "R9");
        prefix(2'd0, 32'd8, 32'd8, 2'd0);
        prefix(2'd3, 32'd99, 32'd99, 2'd0);
        decode(9'd13, 9'd14, 9'd15, 1'b1, "R9");

        // R10: high operand bits ignored
        prefix(2'd0, 32'hFFFF_FE05, 32'hABCD_0003, 2'd0);
        decode(9'd0, 9'd0, 9'd0, 1'b0, "R10");
        cmp("R10", out_r, 9'd8);
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule